// File: doc/BRIEF.md
# SPI Register Slave With Burst Modes

This block is a serial-peripheral slave that gives a host access to a 64-location byte register space. Each transaction opens with one command byte. That byte holds a direction bit, an auto-increment bit and a 6-bit address. Any number of data bytes follow, and the transaction lasts until slave select goes high. With auto-increment set, a burst walks through consecutive locations and wraps from 63 to 0. With it clear, every byte hits the same location. Holding one location is how a host streams bytes into or out of the FIFO port.

All state is clocked by the serial clock alone, so the register space stays readable and writable while any core clock is stopped. The data pin can work as a plain input with a separate output pin (4-wire), or as a shared bidirectional pin (3-wire). An interrupt can be routed out on the data-in pin whenever the slave is not selected.

Top module: `spi_reg_slave`

## Requirements
- R1: The command byte is sent MSB first. Bit 7 set means write and clear means read, bit 6 is auto-increment, and bits 5:0 are the start address. Input bits are sampled on the rising serial-clock edge. Output bits change on the falling edge, and the first bit of each read byte is valid before that byte's first rising edge.
- R2: With auto-increment set, the address advances by one after every data byte and wraps from 63 to 0.
- R3: With auto-increment clear, every data byte accesses the start address. For a plain register, the last written byte is kept, and repeated reads return the same value.
- R4: Address 0x20 is a FIFO of FIFO_DEPTH bytes. A write pushes and a read pops, in first-in-first-out order. A push into a full FIFO is dropped and sets the overflow flag.
- R5: Address 0x21 is a read-only status byte: bit 7 underflow, bit 6 overflow, bit 5 zero, bits 4:0 FIFO fill count. A read of the empty FIFO returns 0x00 and sets the sticky underflow flag. Writes to 0x21 are ignored.
- R6: Raising slave select ends the transaction at any point. A partial byte has no effect, and the next transaction begins with a new command byte.
- R7: In 4-wire mode, read data appears on miso_o, miso_oe_o is high exactly while slave select is low, and the data pin is never driven by the slave during the transaction.
- R8: In 3-wire mode, read data is driven on mosi_o with mosi_oe_o high during the data bytes of a read transaction, miso_oe_o stays low, and write data and commands are taken from the same pin.
- R9: With interrupt routing enabled and slave select high, mosi_oe_o is high, mosi_o follows irq_i and irq_o is low. With routing disabled, irq_o follows irq_i.
- R10: After reset, all plain registers read 0x00, the FIFO is empty and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, idles low |
| cs_ni | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Data pin input (commands and write data in both modes) |
| mosi_o | output | 1 | Data pin output: read data in 3-wire mode, interrupt when routed |
| mosi_oe_o | output | 1 | Data pin output enable |
| miso_o | output | 1 | Read data output in 4-wire mode |
| miso_oe_o | output | 1 | Output enable of miso_o |
| three_wire_i | input | 1 | Selects the shared-pin mode |
| irq_mux_i | input | 1 | Routes the interrupt onto the data pin while deselected |
| irq_i | input | 1 | Interrupt request from the core |
| irq_o | output | 1 | Dedicated interrupt output |

## Verification
The bench builds the block with its defaults: a 16-byte FIFO at 0x20 and status at 0x21. With these values, a 17-byte push reaches the overflow drop and a 17th pop reaches underflow within a short run. Because the address is six bits wide, an incrementing burst that starts at 62 reaches the 63-to-0 wrap. The bench also runs both pin modes, interrupt routing, and a transaction aborted in the middle of a byte.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              wr;
    logic              inc;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/spi_rx_shift.sv
module spi_rx_shift (
  input  logic       sck_i,
  input  logic       txn_rst_ni,
  input  logic       din_i,
  output logic [2:0] bit_cnt_o,
  output logic       byte_done_o,
  output logic [7:0] byte_o
);
  logic [6:0] sh_q;
  logic [2:0] cnt_q;

  always_ff @(posedge sck_i or negedge txn_rst_ni) begin
    if (!txn_rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= {sh_q[5:0], din_i};
      cnt_q <= cnt_q + 3'd1;
    end
  end

  assign bit_cnt_o   = cnt_q;
  assign byte_done_o = (cnt_q == 3'd7);
  assign byte_o      = {sh_q, din_i};
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_reg_pkg::*;
(
  input  logic              sck_i,
  input  logic              txn_rst_ni,
  input  logic              byte_done_i,
  input  logic [7:0]        byte_i,
  output logic              cmd_done_o,
  output logic              wr_o,
  output logic              inc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic              rd_adv_o
);
  cmd_t cmd_q;
  logic cmd_done_q;

  always_ff @(posedge sck_i or negedge txn_rst_ni) begin
    if (!txn_rst_ni) begin
      cmd_q      <= '0;
      cmd_done_q <= 1'b0;
    end else if (byte_done_i) begin
      if (!cmd_done_q) begin
        cmd_q      <= cmd_t'(byte_i);
        cmd_done_q <= 1'b1;
      end else if (cmd_q.inc) begin
        cmd_q.addr <= cmd_q.addr + 1'b1; // 6-bit wrap
      end
    end
  end

  assign cmd_done_o = cmd_done_q;
  assign wr_o       = cmd_q.wr;
  assign inc_o      = cmd_q.inc;
  assign addr_o     = cmd_q.addr;
  assign wr_en_o    = byte_done_i & cmd_done_q & cmd_q.wr;
  assign rd_adv_o   = byte_done_i & cmd_done_q & ~cmd_q.wr;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int              FIFO_DEPTH = 16,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 6'h20,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 6'h21,
  localparam int             CNT_W      = $clog2(FIFO_DEPTH + 1),
  localparam int             PTR_W      = $clog2(FIFO_DEPTH)
) (
  input  logic              sck_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  fifo_cnt_o,
  output logic              underflow_o,
  output logic              overflow_o
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] fifo_q [FIFO_DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              uf_q, of_q;

  logic is_fifo, is_stat, push, pop, full, empty;
  assign is_fifo = (addr_i == FIFO_ADDR);
  assign is_stat = (addr_i == STAT_ADDR);
  assign push    = wr_en_i & is_fifo;
  assign pop     = rd_adv_i & is_fifo;
  assign full    = (cnt_q == CNT_W'(FIFO_DEPTH));
  assign empty   = (cnt_q == '0);

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge sck_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[g] <= '0;
        else if (wr_en_i && addr_i == ADDR_W'(g) && !is_fifo && !is_stat)
          regs_q[g] <= wdata_i;
      end
    end
  endgenerate

  always_ff @(posedge sck_i) begin
    if (push && !full) fifo_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge sck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      uf_q     <= 1'b0;
      of_q     <= 1'b0;
    end else begin
      if (push) begin
        if (full) of_q <= 1'b1;
        else begin
          wr_ptr_q <= (wr_ptr_q == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
          cnt_q    <= cnt_q + 1'b1;
        end
      end
      if (pop) begin
        if (empty) uf_q <= 1'b1;
        else begin
          rd_ptr_q <= (rd_ptr_q == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
          cnt_q    <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (is_fifo)      rdata_o = empty ? '0 : fifo_q[rd_ptr_q];
    else if (is_stat) rdata_o = {uf_q, of_q, 1'b0, 5'(cnt_q)};
    else              rdata_o = regs_q[addr_i];
  end

  assign fifo_cnt_o  = cnt_q;
  assign underflow_o = uf_q;
  assign overflow_o  = of_q;
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift (
  input  logic       sck_i,
  input  logic       txn_rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       bit_o,
  output logic       active_o
);
  logic [7:0] sh_q;
  logic       act_q;

  always_ff @(negedge sck_i or negedge txn_rst_ni) begin
    if (!txn_rst_ni) begin
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= data_i;
      act_q <= 1'b1;
    end else begin
      sh_q  <= {sh_q[6:0], 1'b0};
    end
  end

  assign bit_o    = sh_q[7];
  assign active_o = act_q;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int                FIFO_DEPTH = 16,
  parameter logic [ADDR_W-1:0] FIFO_ADDR  = 6'h20,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 6'h21
) (
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic mosi_o,
  output logic mosi_oe_o,
  output logic miso_o,
  output logic miso_oe_o,
  input  logic three_wire_i,
  input  logic irq_mux_i,
  input  logic irq_i,
  output logic irq_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  // transaction state clears whenever select is released
  logic txn_rst_n;
  assign txn_rst_n = rst_ni & ~cs_ni;

  logic [2:0]        bit_cnt;
  logic              byte_done;
  logic [7:0]        rx_byte;
  logic              cmd_done, cmd_wr, cmd_inc, wr_en, rd_adv;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rdata;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              underflow, overflow;
  logic              tx_bit, tx_act;

  spi_rx_shift u_rx (
    .sck_i(sck_i), .txn_rst_ni(txn_rst_n), .din_i(mosi_i),
    .bit_cnt_o(bit_cnt), .byte_done_o(byte_done), .byte_o(rx_byte)
  );

  spi_cmd_ctrl u_ctrl (
    .sck_i(sck_i), .txn_rst_ni(txn_rst_n), .byte_done_i(byte_done),
    .byte_i(rx_byte), .cmd_done_o(cmd_done), .wr_o(cmd_wr), .inc_o(cmd_inc),
    .addr_o(cur_addr), .wr_en_o(wr_en), .rd_adv_o(rd_adv)
  );

  spi_reg_bank #(
    .FIFO_DEPTH(FIFO_DEPTH), .FIFO_ADDR(FIFO_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_bank (
    .sck_i(sck_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_adv_i(rd_adv),
    .addr_i(cur_addr), .wdata_i(rx_byte), .rdata_o(rdata),
    .fifo_cnt_o(fifo_cnt), .underflow_o(underflow), .overflow_o(overflow)
  );

  spi_tx_shift u_tx (
    .sck_i(sck_i), .txn_rst_ni(txn_rst_n),
    .load_i(cmd_done & ~cmd_wr & (bit_cnt == 3'd0)),
    .data_i(rdata), .bit_o(tx_bit), .active_o(tx_act)
  );

  assign miso_o    = tx_bit;
  assign miso_oe_o = ~cs_ni & ~three_wire_i;
  assign mosi_o    = cs_ni ? irq_i : tx_bit;
  assign mosi_oe_o = cs_ni ? irq_mux_i : (three_wire_i & tx_act);
  assign irq_o     = irq_mux_i ? 1'b0 : irq_i;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             rst_ni,
  input logic             sck_i,
  input logic             cs_ni,
  input logic             byte_done,
  input logic             cmd_done,
  input logic             cmd_inc,
  input logic [5:0]       cur_addr,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             underflow,
  input logic             mosi_oe_o,
  input logic             miso_oe_o
);
  AST_CMD_FROM_BYTE: assert property (@(posedge sck_i) disable iff (!rst_ni || cs_ni)
    $rose(cmd_done) |-> $past(byte_done)); // R1

  AST_ADDR_STEP: assert property (@(posedge sck_i) disable iff (!rst_ni || cs_ni)
    (byte_done && cmd_done && cmd_inc) |=> (!cmd_done || cur_addr == 6'($past(cur_addr) + 6'd1))); // R2

  AST_ADDR_HOLD: assert property (@(posedge sck_i) disable iff (!rst_ni || cs_ni)
    (byte_done && cmd_done && !cmd_inc) |=> (!cmd_done || $stable(cur_addr))); // R3

  AST_FIFO_BOUND: assert property (@(posedge sck_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(FIFO_DEPTH)); // R4

  AST_UNDERFLOW_STICKY: assert property (@(posedge sck_i) disable iff (!rst_ni)
    underflow |=> underflow); // R5

  AST_PIN_EXCLUSIVE: assert property (@(negedge sck_i) disable iff (!rst_ni)
    !(mosi_oe_o && miso_oe_o)); // R8
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .rst_ni(rst_ni), .sck_i(sck_i), .cs_ni(cs_ni), .byte_done(byte_done),
  .cmd_done(cmd_done), .cmd_inc(cmd_inc), .cur_addr(cur_addr),
  .fifo_cnt(fifo_cnt), .underflow(underflow),
  .mosi_oe_o(mosi_oe_o), .miso_oe_o(miso_oe_o)
);

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  localparam int CLK_PERIOD = 20;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam logic [5:0] FADDR = 6'h20;
  localparam logic [5:0] SADDR = 6'h21;
  localparam int DEPTH = 16;

  logic rst_ni = 1'b0, sck = 1'b0, cs_n = 1'b1, host_d = 1'b0;
  logic three_w = 1'b0, irq_mux = 1'b0, irq = 1'b0;
  logic mosi_pad, mosi_o, mosi_oe_o, miso_o, miso_oe_o, irq_o;

  assign mosi_pad = mosi_oe_o ? mosi_o : host_d;

  spi_reg_slave dut (
    .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi_pad),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .three_wire_i(three_w), .irq_mux_i(irq_mux), .irq_i(irq), .irq_o(irq_o)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] tx_buf [64];

  // behavioural reference model
  logic [7:0] m_regs [64];
  logic [7:0] m_q [$];
  bit m_uf = 0, m_of = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_write(input logic [5:0] a, input logic [7:0] d);
    if (a == FADDR) begin
      if (m_q.size() < DEPTH) m_q.push_back(d); else m_of = 1;
    end else if (a != SADDR) m_regs[a] = d;
  endfunction

  function automatic logic [7:0] m_read(input logic [5:0] a);
    if (a == FADDR) begin
      if (m_q.size() == 0) begin m_uf = 1; return 8'h00; end
      return m_q.pop_front();
    end
    if (a == SADDR) return {m_uf, m_of, 1'b0, 5'(m_q.size())};
    return m_regs[a];
  endfunction

  task automatic shift_byte(input logic [7:0] dout, input int nbits, output logic [7:0] din);
    din = '0;
    for (int b = 7; b > 7 - nbits; b--) begin
      host_d = dout[b];
      #(HALF);
      din[b] = three_w ? mosi_o : miso_o;
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic spi_txn(input bit wr, input bit inc, input logic [5:0] a, input int n, input string tag);
    logic [7:0] got, exp;
    logic [5:0] cur;
    cur = a;
    cs_n = 1'b0;
    shift_byte({wr, inc, a}, 8, got);
    for (int i = 0; i < n; i++) begin
      if (wr) begin
        shift_byte(tx_buf[i], 8, got);
        m_write(cur, tx_buf[i]);
      end else begin
        #1;
        if (i == 0) begin
          if (three_w) check(mosi_oe_o && !miso_oe_o, "R8 oe", {mosi_oe_o, miso_oe_o}, 2'b10);
          else         check(miso_oe_o && !mosi_oe_o, "R7 oe", {mosi_oe_o, miso_oe_o}, 2'b01);
        end
        exp = m_read(cur);
        shift_byte(8'h00, 8, got);
        check(got == exp, tag, got, exp);
      end
      if (inc) cur = cur + 6'd1;
    end
    #(HALF);
    cs_n = 1'b1;
    #(CLK_PERIOD);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk;
    for (int i = 0; i < 64; i++) m_regs[i] = 8'h00;
    #(CLK_PERIOD * 2);
    rst_ni = 1'b1;
    #(CLK_PERIOD);

    // R10 reset state
    check(!miso_oe_o && !mosi_oe_o, "R10 idle oe", {mosi_oe_o, miso_oe_o}, 0);
    spi_txn(0, 1, 6'h00, 16, "R10 regs");
    spi_txn(0, 0, SADDR, 1, "R10 status");

    // R1 single write/read
    tx_buf[0] = 8'hA5;
    spi_txn(1, 0, 6'h05, 1, "R1 write");
    spi_txn(0, 0, 6'h05, 1, "R1 readback");

    // R2 incrementing burst with wrap
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33; tx_buf[3] = 8'h44;
    spi_txn(1, 1, 6'd62, 4, "R2 wr");
    spi_txn(0, 1, 6'd62, 4, "R2 wrap read");

    // R3 non-incrementing register burst
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h02; tx_buf[2] = 8'h3C;
    spi_txn(1, 0, 6'd10, 3, "R3 wr");
    spi_txn(0, 0, 6'd10, 3, "R3 repeat read");
    spi_txn(0, 1, 6'd9, 3, "R3 neighbours");

    // R4 FIFO push/pop, R5 underflow
    tx_buf[0] = 8'hD1; tx_buf[1] = 8'hD2; tx_buf[2] = 8'hD3;
    spi_txn(1, 0, FADDR, 3, "R4 push");
    spi_txn(0, 0, SADDR, 1, "R5 count");
    spi_txn(0, 0, FADDR, 4, "R4 R5 pop underflow");
    spi_txn(0, 0, SADDR, 1, "R5 underflow flag");

    // R4 overflow
    for (int i = 0; i < 17; i++) tx_buf[i] = 8'(8'h80 + i);
    spi_txn(1, 0, FADDR, 17, "R4 fill");
    spi_txn(0, 0, SADDR, 1, "R4 overflow flag");
    spi_txn(0, 0, FADDR, 16, "R4 drain order");

    // R5 status write ignored
    tx_buf[0] = 8'h00;
    spi_txn(1, 0, SADDR, 1, "R5 wr");
    spi_txn(0, 0, SADDR, 1, "R5 status kept");

    // R6 abort mid-byte
    tx_buf[0] = 8'h55;
    spi_txn(1, 0, 6'd12, 1, "R6 setup");
    cs_n = 1'b0;
    shift_byte({2'b10, 6'd12}, 8, junk);
    shift_byte(8'hFF, 5, junk);
    #(HALF); cs_n = 1'b1; #(CLK_PERIOD);
    spi_txn(0, 0, 6'd12, 1, "R6 partial ignored");
    cs_n = 1'b0;
    shift_byte(8'hC0, 3, junk);
    #(HALF); cs_n = 1'b1; #(CLK_PERIOD);
    spi_txn(0, 0, 6'd12, 1, "R6 fresh command");

    // R8 3-wire mode
    three_w = 1'b1;
    tx_buf[0] = 8'hC3; tx_buf[1] = 8'h3C;
    spi_txn(1, 1, 6'd40, 2, "R8 wr");
    spi_txn(0, 1, 6'd40, 2, "R8 read");
    three_w = 1'b0;

    // R9 interrupt routing
    irq = 1'b1; #1;
    check(irq_o == 1'b1 && !mosi_oe_o, "R9 direct irq", {irq_o, mosi_oe_o}, 2'b10);
    irq_mux = 1'b1; #1;
    check(mosi_oe_o && mosi_o && !irq_o, "R9 routed high", {mosi_oe_o, mosi_o, irq_o}, 3'b110);
    irq = 1'b0; #1;
    check(mosi_oe_o && !mosi_o, "R9 routed low", {mosi_oe_o, mosi_o}, 2'b10);
    irq = 1'b1;
    cs_n = 1'b0; #1;
    check(!mosi_oe_o, "R9 released while selected", mosi_oe_o, 0);
    #(HALF); cs_n = 1'b1; #(CLK_PERIOD);
    tx_buf[0] = 8'h6E;
    spi_txn(1, 0, 6'd3, 1, "R9 wr");
    spi_txn(0, 0, 6'd3, 1, "R9 write under routing");
    irq_mux = 1'b0; irq = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule